// File: doc/BRIEF.md
# DMA Channel Event Flags and Interrupt

This block holds the event flags of one DMA channel and raises that channel's interrupt. It watches four things. The first is every address the channel uses, compared against a programmable low limit and a programmable high limit. The second is the channel's down-counter, checked for the halfway point and for the end of the session. The third is a trigger that arrives while the channel is still busy. The fourth is a one-word buffer that holds data waiting to be stored in null-write mode.

Each event sets a sticky flag in a 16-bit register that software can read and write. The same register also holds a 7-bit trigger-select field and a halfway-interrupt enable bit. The limit checks look at addresses that have already been used: an out-of-range access still happens, and the flag reports it afterwards. The address datapath, the bus master, arbitration between channels and the data movement itself are outside the block. They reach it only as strobes, addresses and counter values.

The interrupt output is a one-cycle pulse on the clock edge after a hardware event. It comes from a limit violation, an overrun, a completed session, or a halfway event when the halfway enable bit is set. Flags that software sets never cause an interrupt.

Top module: `dma_chan_irq`

## Requirements
- R1: After reset, every register bit reads 0 and `irq` is 0.
- R2: Register layout: bit 15 is the pending-store flag, bits 14:8 are the trigger select, bit 7 is the high-limit flag, bit 6 the low-limit flag, bit 5 the done flag, bit 4 the halfway flag, bit 3 the overrun flag and bit 0 the halfway enable. Bits 2:1 always read 0. The trigger select and the halfway enable hold the value last written.
- R3: When `acc_valid` is high and `acc_addr` is above `lim_hi` or above `RAM_TOP` (0xBFFF by default), the high-limit flag is set at that edge. An address equal to the limit does not set it.
- R4: When `acc_valid` is high, `acc_addr` is below `lim_lo` and `acc_addr` is above `SFR_TOP` (0x07FF), the low-limit flag is set. An address at or below 0x07FF never sets it.
- R5: When `trig` and `busy` are high in the same cycle, the overrun flag is set.
- R6: `sess_start` latches `cnt_init >> 1` as the midpoint. The first `cnt_step` of the session whose `cnt_val` equals the midpoint sets the halfway flag. This happens at most once per session, and not in the cycle of `sess_start`.
- R7: `sess_done` sets the done flag. `sess_start` clears it unless `sess_done` is high in the same cycle.
- R8: `buf_load` sets the pending-store flag and `buf_store` clears it. If both are high in the same cycle, the flag is set.
- R9: `irq` is high for exactly the cycle after an edge at which a limit, overrun or done event occurred, or a halfway event occurred while the halfway enable read 1 before that edge. A halfway event with the enable at 0 gives no pulse.
- R10: A register write loads every flag from `reg_wdata`, writing 1 sets a flag and writing 0 clears it, but a hardware set in the same cycle wins. A write alone never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| lim_lo | input | AW | Low address limit |
| lim_hi | input | AW | High address limit |
| acc_valid | input | 1 | An access was made this cycle |
| acc_addr | input | AW | Address used by that access |
| trig | input | 1 | Channel trigger |
| busy | input | 1 | Channel still serving the previous trigger |
| sess_start | input | 1 | Session begins |
| cnt_init | input | CW | Initial count of the session |
| cnt_step | input | 1 | Counter updated this cycle |
| cnt_val | input | CW | Current counter value |
| sess_done | input | 1 | Session completed |
| buf_load | input | 1 | Data captured into the null-write buffer |
| buf_store | input | 1 | Buffered data written to its destination |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest case to reach is a hardware event and a software write that hit the same flag in the same cycle, together with the halfway event, which fires only once per session and only when the counter exactly equals a midpoint latched at session start. The bench drives short sessions with small initial counts, so the counter passes its midpoint often. It writes the register at random, so writes collide with events. It also picks addresses from a set concentrated on each limit and on the 0x07FF boundary, so the edge values come up often. Directed steps cover the exact boundary addresses, and a halfway event with the enable both off and on.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int REG_W    = 16;
   localparam int B_PEND   = 15;
   localparam int SEL_LSB  = 8;
   localparam int SEL_W    = 7;
   localparam int B_HI     = 7;
   localparam int B_LO     = 6;
   localparam int B_DONE   = 5;
   localparam int B_HALF   = 4;
   localparam int B_OVR    = 3;
   localparam int B_HEN    = 0;

   typedef struct packed {
      logic hi;
      logic lo;
      logic ovr;
      logic half;
      logic done;
   } evt_t;
endpackage

// File: rtl/dma_irq_limchk.sv
module dma_irq_limchk #(
   parameter int          AW      = 16,
   parameter logic [AW-1:0] SFR_TOP = 'h07FF,
   parameter logic [AW-1:0] RAM_TOP = 'hBFFF
) (
   input  logic          acc_valid,
   input  logic [AW-1:0] acc_addr,
   input  logic [AW-1:0] lim_lo,
   input  logic [AW-1:0] lim_hi,
   output logic          ev_hi,
   output logic          ev_lo
);
   logic above_lim, above_ram, below_lim, above_sfr;

   always_comb begin
      above_lim = acc_addr > lim_hi;
      above_ram = acc_addr > RAM_TOP;
      below_lim = acc_addr < lim_lo;
      above_sfr = acc_addr > SFR_TOP;
      ev_hi     = acc_valid && (above_lim || above_ram);
      ev_lo     = acc_valid && below_lim && above_sfr;
   end
endmodule

// File: rtl/dma_irq_halfwm.sv
module dma_irq_halfwm #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sess_start,
   input  logic [CW-1:0] cnt_init,
   input  logic          cnt_step,
   input  logic [CW-1:0] cnt_val,
   output logic          ev_half
);
   logic [CW-1:0] mid_q;
   logic          seen_q;

   assign ev_half = cnt_step && !sess_start && !seen_q && (cnt_val == mid_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_q  <= '0;
         seen_q <= 1'b0;
      end else if (sess_start) begin
         mid_q  <= cnt_init >> 1;
         seen_q <= 1'b0;
      end else if (ev_half) begin
         seen_q <= 1'b1;
      end
   end

   // R6
   half_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_half && !sess_start) |=> !ev_half);
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
   import dma_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  evt_t             ev,
   input  logic             sess_start,
   input  logic             buf_load,
   input  logic             buf_store,
   output logic [REG_W-1:0] reg_q,
   output logic             half_en
);
   logic             pend_q, hi_q, lo_q, done_q, half_q, ovr_q, hen_q;
   logic [SEL_W-1:0] sel_q;
   logic             unused_bits;

   assign unused_bits = ^reg_wdata[2:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         sel_q  <= '0;
         hi_q   <= 1'b0;
         lo_q   <= 1'b0;
         done_q <= 1'b0;
         half_q <= 1'b0;
         ovr_q  <= 1'b0;
         hen_q  <= 1'b0;
      end else begin
         pend_q <= buf_load ? 1'b1 : buf_store ? 1'b0
                 : (reg_wr ? reg_wdata[B_PEND] : pend_q);
         if (reg_wr) begin
            sel_q <= reg_wdata[SEL_LSB +: SEL_W];
            hen_q <= reg_wdata[B_HEN];
         end
         hi_q   <= ev.hi   | (reg_wr ? reg_wdata[B_HI]   : hi_q);
         lo_q   <= ev.lo   | (reg_wr ? reg_wdata[B_LO]   : lo_q);
         half_q <= ev.half | (reg_wr ? reg_wdata[B_HALF] : half_q);
         ovr_q  <= ev.ovr  | (reg_wr ? reg_wdata[B_OVR]  : ovr_q);
         done_q <= ev.done | (!sess_start && (reg_wr ? reg_wdata[B_DONE] : done_q));
      end
   end

   always_comb begin
      reg_q          = '0;
      reg_q[B_PEND]  = pend_q;
      reg_q[SEL_LSB +: SEL_W] = sel_q;
      reg_q[B_HI]    = hi_q;
      reg_q[B_LO]    = lo_q;
      reg_q[B_DONE]  = done_q;
      reg_q[B_HALF]  = half_q;
      reg_q[B_OVR]   = ovr_q;
      reg_q[B_HEN]   = hen_q;
      half_en        = hen_q;
   end

   // R3
   hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev.hi |=> reg_q[B_HI]);
   // R7
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sess_start && !ev.done) |=> !reg_q[B_DONE]);
   // R8
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_load |=> reg_q[B_PEND]);
   // R10
   sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[B_OVR]) |=> reg_q[B_OVR]);
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
   import dma_irq_pkg::*;
#(
   parameter int            AW      = 16,
   parameter int            CW      = 16,
   parameter logic [AW-1:0] SFR_TOP = 'h07FF,
   parameter logic [AW-1:0] RAM_TOP = 'hBFFF,
   parameter bit            IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [AW-1:0]    lim_lo,
   input  logic [AW-1:0]    lim_hi,
   input  logic             acc_valid,
   input  logic [AW-1:0]    acc_addr,
   input  logic             trig,
   input  logic             busy,
   input  logic             sess_start,
   input  logic [CW-1:0]    cnt_init,
   input  logic             cnt_step,
   input  logic [CW-1:0]    cnt_val,
   input  logic             sess_done,
   input  logic             buf_load,
   input  logic             buf_store,
   output logic             irq
);
   localparam int MIN_AW = 12;

   generate
      if (AW < MIN_AW) begin : g_aw_bad
         $error("AW too small for the SFR boundary");
      end
      if (CW < 2) begin : g_cw_bad
         $error("CW must be at least 2");
      end
      if (SFR_TOP >= RAM_TOP) begin : g_map_bad
         $error("SFR_TOP must lie below RAM_TOP");
      end
   endgenerate

   evt_t ev;
   logic half_en, irq_ev;

   dma_irq_limchk #(.AW(AW), .SFR_TOP(SFR_TOP), .RAM_TOP(RAM_TOP)) u_lim (
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .lim_lo    (lim_lo),
      .lim_hi    (lim_hi),
      .ev_hi     (ev.hi),
      .ev_lo     (ev.lo)
   );

   dma_irq_halfwm #(.CW(CW)) u_half (
      .clk        (clk),
      .rst_n      (rst_n),
      .sess_start (sess_start),
      .cnt_init   (cnt_init),
      .cnt_step   (cnt_step),
      .cnt_val    (cnt_val),
      .ev_half    (ev.half)
   );

   assign ev.ovr  = trig && busy;
   assign ev.done = sess_done;

   dma_irq_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .ev         (ev),
      .sess_start (sess_start),
      .buf_load   (buf_load),
      .buf_store  (buf_store),
      .reg_q      (reg_rdata),
      .half_en    (half_en)
   );

   assign irq_ev = ev.hi | ev.lo | ev.ovr | ev.done | (ev.half & half_en);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_ev;
         end
         assign irq = irq_q;

         // R9
         done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sess_done |=> irq);
         // R4
         sfr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_addr <= SFR_TOP && !trig && !sess_done
             && !ev.half && acc_addr <= lim_hi) |=> !irq);
      end else begin : g_irq_comb
         assign irq = irq_ev;
      end
   endgenerate
endmodule

// File: tb/sim_dma_chan_irq.sv
module sim_dma_chan_irq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int CW = 16;
   localparam logic [15:0] SFR_TOP = 16'h07FF;
   localparam logic [15:0] RAM_TOP = 16'hBFFF;
   localparam int N_RAND = 4000;

   logic clk = 0, rst_n = 0;
   logic reg_wr = 0, acc_valid = 0, trig = 0, busy = 0, sess_start = 0;
   logic cnt_step = 0, sess_done = 0, buf_load = 0, buf_store = 0;
   logic [15:0] reg_wdata = 0, lim_lo = 16'h2000, lim_hi = 16'h8000, acc_addr = 0;
   logic [CW-1:0] cnt_init = 0, cnt_val = 0;
   logic [15:0] reg_rdata;
   logic irq;

   int checks = 0, fails = 0;
   logic [15:0] m_reg = 0;
   logic [CW-1:0] m_mid = 0;
   logic m_seen = 0, m_irq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_irq #(.AW(AW), .CW(CW)) u0 (.*);

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model_next(input logic [15:0] r, output logic ev_half_o,
                                              output logic irq_o);
      logic [15:0] n;
      logic hi, lo, ov, hf;
      hi = acc_valid && (acc_addr > lim_hi || acc_addr > RAM_TOP);
      lo = acc_valid && acc_addr < lim_lo && acc_addr > SFR_TOP;
      ov = trig && busy;
      hf = cnt_step && !sess_start && !m_seen && cnt_val == m_mid;
      n = reg_wr ? (reg_wdata & 16'hFFF9) : r;
      if (buf_store) n[15] = 0;
      if (buf_load)  n[15] = 1;
      if (sess_start) n[5] = 0;
      if (hi) n[7] = 1;
      if (lo) n[6] = 1;
      if (sess_done) n[5] = 1;
      if (hf) n[4] = 1;
      if (ov) n[3] = 1;
      ev_half_o = hf;
      irq_o = hi | lo | ov | sess_done | (hf & r[0]);
      return n;
   endfunction

   task automatic compare();
      chk(reg_rdata[15] == m_reg[15], "R8 pend", reg_rdata[15], m_reg[15]);
      chk(reg_rdata[14:8] == m_reg[14:8] && reg_rdata[2:0] == m_reg[2:0],
          "R2 sel/en", reg_rdata, m_reg);
      chk(reg_rdata[7] == m_reg[7], "R3 hi", reg_rdata[7], m_reg[7]);
      chk(reg_rdata[6] == m_reg[6], "R4 lo", reg_rdata[6], m_reg[6]);
      chk(reg_rdata[5] == m_reg[5], "R7 done", reg_rdata[5], m_reg[5]);
      chk(reg_rdata[4] == m_reg[4], "R6 half", reg_rdata[4], m_reg[4]);
      chk(reg_rdata[3] == m_reg[3], "R5 ovr", reg_rdata[3], m_reg[3]);
      chk(irq == m_irq, "R9/R10 irq", irq, m_irq);
   endtask

   // Inputs are already set; advance one edge, update model, compare, clear strobes.
   task automatic cyc();
      logic hf, ir;
      logic [15:0] nr;
      nr = model_next(m_reg, hf, ir);
      if (sess_start) begin m_mid = cnt_init >> 1; m_seen = 0; end
      else if (hf) m_seen = 1;
      @(posedge clk);
      m_reg = nr; m_irq = ir;
      @(negedge clk);
      compare();
      reg_wr = 0; acc_valid = 0; trig = 0; busy = 0; sess_start = 0;
      cnt_step = 0; sess_done = 0; buf_load = 0; buf_store = 0;
   endtask

   function automatic logic [15:0] pick_addr();
      case ($urandom_range(0, 7))
         0: return SFR_TOP;
         1: return SFR_TOP + 1;
         2: return lim_hi;
         3: return lim_hi + 1;
         4: return lim_lo - 1;
         5: return RAM_TOP + 1;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [CW-1:0] cnt;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(reg_rdata == 0 && irq == 0, "R1 reset", reg_rdata, 0);
      rst_n = 1;
      @(negedge clk);
      chk(reg_rdata == 0 && irq == 0, "R1 after release", reg_rdata, 0);

      // R4 boundary: 0x07FF no flag, 0x0800 flags
      acc_valid = 1; acc_addr = 16'h07FF; cyc();
      acc_valid = 1; acc_addr = 16'h0800; cyc();
      // R3 boundary: equal to limit no flag, one above flags
      reg_wr = 1; reg_wdata = 16'h0000; cyc();
      acc_valid = 1; acc_addr = lim_hi; cyc();
      acc_valid = 1; acc_addr = lim_hi + 1; cyc();
      // R3 above RAM top with a wide limit
      reg_wr = 1; reg_wdata = 0; cyc();
      lim_hi = 16'hFFFF; acc_valid = 1; acc_addr = 16'hC000; cyc();
      lim_hi = 16'h8000;
      // R10 software write 1 on every flag, no irq; then clear
      reg_wr = 1; reg_wdata = 16'hFFF9; cyc();
      cyc();
      reg_wr = 1; reg_wdata = 16'h0000; cyc();
      // R10 hw event beats sw write 0 in the same cycle
      reg_wr = 1; reg_wdata = 0; trig = 1; busy = 1; cyc();
      // R6/R9 halfway, enable off then on
      sess_start = 1; cnt_init = 8; cyc();
      cnt_step = 1; cnt_val = 4; cyc();
      cnt_step = 1; cnt_val = 4; cyc();
      reg_wr = 1; reg_wdata = 16'h0001; cyc();
      sess_start = 1; cnt_init = 9; cyc();
      cnt_step = 1; cnt_val = 4; cyc();
      // R7 done then cleared by start; R8 pend set, store clears, both sets
      sess_done = 1; cyc();
      sess_start = 1; cnt_init = 6; cyc();
      buf_load = 1; cyc();
      buf_store = 1; cyc();
      buf_load = 1; buf_store = 1; cyc();

      // random phase
      cnt = 0;
      for (int i = 0; i < N_RAND; i++) begin
         if ($urandom_range(0, 7) == 0) begin
            reg_wr = 1; reg_wdata = 16'($urandom);
         end
         if ($urandom_range(0, 1) == 0) begin
            acc_valid = 1; acc_addr = pick_addr();
         end
         trig = ($urandom_range(0, 5) == 0);
         busy = $urandom_range(0, 1);
         if ($urandom_range(0, 15) == 0) begin
            sess_start = 1; cnt_init = CW'($urandom_range(1, 40));
            cnt = cnt_init;
         end else if (cnt != 0 && $urandom_range(0, 1) == 0) begin
            cnt = cnt - 1; cnt_step = 1; cnt_val = cnt;
            sess_done = (cnt == 0);
         end
         if ($urandom_range(0, 19) == 0) sess_done = 1;
         buf_load  = ($urandom_range(0, 7) == 0);
         buf_store = ($urandom_range(0, 7) == 0);
         if ($urandom_range(0, 31) == 0) begin
            lim_lo = 16'($urandom); lim_hi = 16'($urandom);
         end
         cyc();
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule